// File: doc/BRIEF.md
# Trap and Machine-Status Register Unit

This unit handles interrupts and exceptions for a small 32-bit RISC-V style core. It holds four machine status registers: a status word, a cause word, a saved exception PC and a trap vector. It decides each cycle whether the core must leave its normal flow. The core gives it decoded trap requests, the current instruction PC and the fields of a CSR access. The unit answers in the same cycle with a redirect strobe and a target PC. The register updates take effect on the next clock edge.

The scheme is a cut-down one. There is one external-interrupt enable bit and one saved copy of it. Only the CSR swap operation exists. Each register can be reached at a read-write address and at a read-only address. Any other CSR access, any write through a read-only address and any unknown address count as an illegal instruction.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset, the status, cause and exception-PC registers read 0, and the trap-vector register reads the parameter VEC_DEFAULT (default 0x100).
- R2: The status register holds the enable bit at bit 0 and the saved-enable bit at bit 1; all other bits read 0. On any taken trap, bit 1 receives the old bit 0 and bit 0 becomes 0.
- R3: When mret is taken, the redirect target is the exception-PC register. In the next cycle the enable bit equals the saved-enable bit, and the saved-enable bit is unchanged.
- R4: An external interrupt is ignored while the enable bit is 0, and a held request is taken once the enable bit is 1. Priority runs from software traps, to mret, to external interrupts, so a request that loses in one cycle stays pending for later cycles.
- R5: The software traps (illegal instruction, ebreak, ecall) are taken whatever the enable bit holds. When several are asserted together, illegal wins over ebreak, and ebreak wins over ecall.
- R6: The cause register is written as follows: external interrupt 0x8000000B, illegal instruction 0x00000002, ebreak 0x00000003, ecall 0x0000000B. Bits 30..4 always read 0.
- R7: On any taken trap, the exception-PC register captures the PC presented that cycle. For a software trap this is the trapping instruction. For an interrupt it is the instruction that was not executed, which is also the resume address.
- R8: A taken trap redirects to the current trap-vector value, and software can change that value through a swap.
- R9: A swap uses op code 3'b001 with write enable set, at read-write address 0x7C0+n (n = 0 status, 1 cause, 2 exception PC, 3 vector). It returns the old value on csr_rdata_o in the same cycle. From the next cycle the register holds the written value masked: status keeps bits 1..0, cause keeps bits 31 and 3..0, and the other two keep all bits.
- R10: A swap with write enable clear at read-only address 0xFC0+n returns the value and leaves the register unchanged.
- R11: Any op other than 3'b001, a write-enabled swap to a read-only address, or an address outside both ranges raises csr_illegal_o. That access is then taken as an illegal-instruction trap, and the addressed register is not written.
- R12: A CSR write in the same cycle as a taken external interrupt is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC of the instruction presented this cycle |
| ext_irq_i | input | 1 | External interrupt request level |
| illegal_i | input | 1 | Decoder found an illegal instruction |
| ebreak_i | input | 1 | ebreak instruction |
| ecall_i | input | 1 | ecall instruction |
| mret_i | input | 1 | Return-from-trap instruction |
| csr_access_i | input | 1 | A CSR instruction is presented |
| csr_op_i | input | 3 | CSR operation code (3'b001 is swap) |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | The access writes (source register non-zero) |
| csr_wdata_i | input | 32 | Value to swap in |
| csr_rdata_o | output | 32 | Old value of the addressed register |
| csr_illegal_o | output | 1 | The CSR access is unsupported |
| redirect_o | output | 1 | Core must jump this cycle |
| redirect_pc_o | output | 32 | Jump target |

## Verification
Swaps are swept over all four registers with all-ones, mixed and zero patterns. This separates the per-register write masks and shows the old-value return next to the new-value readback. Every op code other than swap is tried, along with read-only writes and an unknown address, to show the illegal path both traps and leaves the register untouched. Each software trap is raised with the enable bit both clear and set, to tell the unconditional traps apart from the masked interrupt and to check the saved-enable copy. Requests are also stacked in the same cycle (trap plus interrupt, mret plus interrupt, interrupt plus CSR write) to expose the priority order and the pending behaviour.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  localparam int NUM_CSR    = 4;
  localparam int IDX_STATUS = 0;
  localparam int IDX_CAUSE  = 1;
  localparam int IDX_EPC    = 2;
  localparam int IDX_VECTOR = 3;

  localparam logic [2:0] OP_SWAP = 3'b001;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_ILLEGAL,
    TK_EBREAK,
    TK_ECALL,
    TK_EXTIRQ,
    TK_RETURN
  } trap_kind_e;

  // cause word written for each trap kind
  function automatic logic [31:0] cause_code(input trap_kind_e k);
    case (k)
      TK_EXTIRQ:  cause_code = 32'h8000_000B;
      TK_ILLEGAL: cause_code = 32'h0000_0002;
      TK_EBREAK:  cause_code = 32'h0000_0003;
      TK_ECALL:   cause_code = 32'h0000_000B;
      default:    cause_code = 32'h0000_0000;
    endcase
  endfunction

  // bits that software may set in each register
  function automatic logic [31:0] write_mask(input int idx);
    case (idx)
      IDX_STATUS: write_mask = 32'h0000_0003;
      IDX_CAUSE:  write_mask = 32'h8000_000F;
      default:    write_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode
  import trap_csr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int RW_BASE = 12'h7C0,
  parameter int RO_BASE = 12'hFC0
) (
  input  logic                       access,
  input  logic [2:0]                 op,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  output logic                       hit,
  output logic [$clog2(NUM_CSR)-1:0] sel,
  output logic                       bad,
  output logic                       write_req
);
  localparam int IDX_W = $clog2(NUM_CSR);

  logic [NUM_CSR-1:0] rw_hit;
  logic [NUM_CSR-1:0] ro_hit;
  logic               any_ro;

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
    assign rw_hit[g] = (addr == ADDR_W'(RW_BASE + g));
    assign ro_hit[g] = (addr == ADDR_W'(RO_BASE + g));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (rw_hit[i] || ro_hit[i]) sel = IDX_W'(i);
    end
  end

  assign hit       = |{rw_hit, ro_hit};
  assign any_ro    = |ro_hit;
  assign bad       = access && ((op != OP_SWAP) || !hit || (any_ro && we));
  assign write_req = access && !bad && we && (|rw_hit);

endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_csr_pkg::*;
(
  input  logic       illegal_req,
  input  logic       ebreak_req,
  input  logic       ecall_req,
  input  logic       mret_req,
  input  logic       irq_req,
  input  logic       irq_enable,
  output trap_kind_e kind,
  output logic       trap_taken,
  output logic       mret_taken,
  output logic       irq_taken
);
  always_comb begin
    if (illegal_req)                kind = TK_ILLEGAL;
    else if (ebreak_req)            kind = TK_EBREAK;
    else if (ecall_req)             kind = TK_ECALL;
    else if (mret_req)              kind = TK_RETURN;
    else if (irq_req && irq_enable) kind = TK_EXTIRQ;
    else                            kind = TK_NONE;
  end

  assign mret_taken = (kind == TK_RETURN);
  assign irq_taken  = (kind == TK_EXTIRQ);
  assign trap_taken = (kind != TK_NONE) && (kind != TK_RETURN);

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          RW_BASE     = 12'h7C0,
  parameter int          RO_BASE     = 12'hFC0,
  parameter logic [31:0] VEC_DEFAULT = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pc_i,
  input  logic              ext_irq_i,
  input  logic              illegal_i,
  input  logic              ebreak_i,
  input  logic              ecall_i,
  input  logic              mret_i,
  input  logic              csr_access_i,
  input  logic [2:0]        csr_op_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  output logic              csr_illegal_o,
  output logic              redirect_o,
  output logic [31:0]       redirect_pc_o
);
  localparam int IDX_W = $clog2(NUM_CSR);

  logic [31:0] csr_q [NUM_CSR];
  logic [31:0] csr_d [NUM_CSR];

  // named internal events
  logic             csr_hit;
  logic [IDX_W-1:0] csr_sel;
  logic             csr_bad;
  logic             csr_write;
  trap_kind_e       trap_kind;
  logic             trap_taken;
  logic             mret_taken;
  logic             irq_taken;
  logic             irq_enable;
  logic             irq_saved;
  logic [31:0]      epc_q;
  logic [31:0]      vector_q;

  assign irq_enable = csr_q[IDX_STATUS][0];
  assign irq_saved  = csr_q[IDX_STATUS][1];
  assign epc_q      = csr_q[IDX_EPC];
  assign vector_q   = csr_q[IDX_VECTOR];

  csr_port_decode #(
    .ADDR_W (ADDR_W),
    .RW_BASE(RW_BASE),
    .RO_BASE(RO_BASE)
  ) decode_i (
    .access   (csr_access_i),
    .op       (csr_op_i),
    .addr     (csr_addr_i),
    .we       (csr_we_i),
    .hit      (csr_hit),
    .sel      (csr_sel),
    .bad      (csr_bad),
    .write_req(csr_write)
  );

  trap_select select_i (
    .illegal_req(illegal_i || csr_bad),
    .ebreak_req (ebreak_i),
    .ecall_req  (ecall_i),
    .mret_req   (mret_i),
    .irq_req    (ext_irq_i),
    .irq_enable (irq_enable),
    .kind       (trap_kind),
    .trap_taken (trap_taken),
    .mret_taken (mret_taken),
    .irq_taken  (irq_taken)
  );

  // next-state: traps first, then return, then software write
  always_comb begin
    for (int i = 0; i < NUM_CSR; i++) csr_d[i] = csr_q[i];
    if (trap_taken) begin
      csr_d[IDX_STATUS] = {30'b0, irq_enable, 1'b0};
      csr_d[IDX_CAUSE]  = cause_code(trap_kind);
      csr_d[IDX_EPC]    = pc_i;
    end else if (mret_taken) begin
      csr_d[IDX_STATUS] = {30'b0, irq_saved, irq_saved};
    end else if (csr_write) begin
      csr_d[csr_sel] = csr_wdata_i & write_mask(int'(csr_sel));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CSR; i++) begin
        csr_q[i] <= (i == IDX_VECTOR) ? VEC_DEFAULT : 32'h0;
      end
    end else begin
      for (int i = 0; i < NUM_CSR; i++) csr_q[i] <= csr_d[i];
    end
  end

  assign csr_rdata_o   = (csr_access_i && csr_hit && !csr_bad) ? csr_q[csr_sel] : 32'h0;
  assign csr_illegal_o = csr_bad;
  assign redirect_o    = trap_taken || mret_taken;
  assign redirect_pc_o = mret_taken ? epc_q : vector_q;

endmodule

// File: rtl/trap_csr_checker.sv
module trap_csr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_i,
  input logic        ext_irq_i,
  input logic        illegal_i,
  input logic        ebreak_i,
  input logic        ecall_i,
  input logic        mret_i,
  input logic        csr_illegal_o,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic        trap_taken,
  input logic        mret_taken,
  input logic [31:0] status_q,
  input logic [31:0] cause_q,
  input logic [31:0] epc_q,
  input logic [31:0] vector_q
);

  a_r2_save_and_mask: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> (status_q[0] == 1'b0) && (status_q[1] == $past(status_q[0])));

  a_r3_restore_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mret_taken |=> (status_q[0] == $past(status_q[1])));

  a_r3_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    mret_taken |-> redirect_o && (redirect_pc_o == epc_q));

  a_r4_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq_i && !status_q[0] && !illegal_i && !ebreak_i && !ecall_i
     && !mret_i && !csr_illegal_o) |-> !redirect_o);

  a_r5_sw_always: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_i || ebreak_i || ecall_i) |-> redirect_o && (redirect_pc_o == vector_q));

  a_r6_cause_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[30:4] == 27'h0);

  a_r7_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> (epc_q == $past(pc_i)));

  a_r11_bad_csr_traps: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal_o |=> (cause_q == 32'h0000_0002));

endmodule

bind trap_csr_unit trap_csr_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pc_i         (pc_i),
  .ext_irq_i    (ext_irq_i),
  .illegal_i    (illegal_i),
  .ebreak_i     (ebreak_i),
  .ecall_i      (ecall_i),
  .mret_i       (mret_i),
  .csr_illegal_o(csr_illegal_o),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o),
  .trap_taken   (trap_taken),
  .mret_taken   (mret_taken),
  .status_q     (csr_q[0]),
  .cause_q      (csr_q[1]),
  .epc_q        (csr_q[2]),
  .vector_q     (csr_q[3])
);

// File: tb/trap_csr_unit_tb.sv
module trap_csr_unit_tb_top;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [11:0] RWB  = 12'h7C0;
  localparam logic [11:0] ROB  = 12'hFC0;
  localparam logic [31:0] VEC0 = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc;
  logic        irq, ill, ebk, ecl, ret, acc, we;
  logic [2:0]  op;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        bad;
  logic        redir;
  logic [31:0] redir_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_csr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .ext_irq_i(irq),
    .illegal_i(ill), .ebreak_i(ebk), .ecall_i(ecl), .mret_i(ret),
    .csr_access_i(acc), .csr_op_i(op), .csr_addr_i(addr), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_illegal_o(bad),
    .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  function automatic logic [31:0] mask_of(input int idx);
    if (idx == 0) return 32'h3;
    if (idx == 1) return 32'h8000_000F;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic go();
    @(negedge clk);
    irq = 0; ill = 0; ebk = 0; ecl = 0; ret = 0; acc = 0; we = 0;
    op = 3'b000; addr = '0; wdata = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    go();
    acc = 1; op = 3'b001; addr = ROB + 12'(idx); we = 0;
    #1 v = rdata;
  endtask

  task automatic swp(input int idx, input logic [31:0] wd, output logic [31:0] old);
    go();
    acc = 1; op = 3'b001; addr = RWB + 12'(idx); we = 1; wdata = wd;
    #1 old = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    report();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_5678; pats[2] = 32'h0;
    pc = 0; irq = 0; ill = 0; ebk = 0; ecl = 0; ret = 0; acc = 0; we = 0;
    op = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset values
    for (int i = 0; i < 4; i++) begin
      m[i] = (i == 3) ? VEC0 : 32'h0;
      rd(i, v);
      check("R1 reset value", v, m[i]);
    end
    check("R10 legal read not flagged", {31'b0, bad}, 32'h0);

    // R9 swap sweep, R10 read-only readback
    foreach (pats[p]) begin
      for (int i = 0; i < 4; i++) begin
        swp(i, pats[p], v);
        check("R9 swap returns old", v, m[i]);
        m[i] = pats[p] & mask_of(i);
        rd(i, v);
        check("R9 masked new value", v, m[i]);
        rd(i, v);
        check("R10 read-only keeps value", v, m[i]);
      end
    end
    swp(3, 32'h200, v);
    m[3] = 32'h200;

    // R11 unsupported ops
    for (int o = 0; o < 8; o++) begin
      if (o != 1) begin
        go();
        acc = 1; op = 3'(o); addr = RWB + 12'd2; we = 1; wdata = 32'hDEAD_BEEF;
        pc = 32'h1000 + 32'(o * 4);
        #1 check("R11 op flagged", {31'b0, bad}, 32'h1);
        check("R11 op redirects to vector", redir_pc, 32'h200);
        rd(2, v);
        check("R11 register not written", v, 32'h1000 + 32'(o * 4));
        rd(1, v);
        check("R11 illegal cause", v, 32'h2);
      end
    end
    go();
    acc = 1; op = 3'b001; addr = ROB + 12'd3; we = 1; wdata = 32'h0; pc = 32'h2000;
    #1 check("R11 read-only write flagged", {31'b0, bad}, 32'h1);
    rd(3, v);
    check("R11 vector untouched", v, 32'h200);
    go();
    acc = 1; op = 3'b001; addr = 12'h123; pc = 32'h2004;
    #1 check("R11 unknown address flagged", {31'b0, bad}, 32'h1);

    // R4 masked interrupt
    for (int k = 0; k < 3; k++) begin
      go(); irq = 1; pc = 32'h2100;
      #1 check("R4 masked irq ignored", {31'b0, redir}, 32'h0);
    end
    swp(0, 32'h1, v);
    go(); irq = 1; pc = 32'h3000;
    #1 check("R4 enabled irq taken", {31'b0, redir}, 32'h1);
    check("R8 irq goes to vector", redir_pc, 32'h200);
    rd(0, v); check("R2 status after trap", v, 32'h2);
    rd(1, v); check("R6 irq cause", v, 32'h8000_000B);
    rd(2, v); check("R7 irq resume address", v, 32'h3000);

    // R3 return
    go(); ret = 1;
    #1 check("R3 mret redirect", {31'b0, redir}, 32'h1);
    check("R3 mret target", redir_pc, 32'h3000);
    rd(0, v); check("R3 enable restored", v, 32'h3);

    // R5 priority and pending
    go(); ecl = 1; irq = 1; pc = 32'h4000;
    #1 check("R5 ecall over irq target", redir_pc, 32'h200);
    rd(1, v); check("R5 ecall cause wins", v, 32'hB);
    go(); irq = 1; pc = 32'h4004;
    #1 check("R4 pending irq masked in handler", {31'b0, redir}, 32'h0);
    go(); ret = 1; irq = 1;
    #1 check("R4 mret beats irq", redir_pc, 32'h4000);
    go(); irq = 1; pc = 32'h5000;
    #1 check("R4 pending irq taken", {31'b0, redir}, 32'h1);
    rd(1, v); check("R4 pending irq cause", v, 32'h8000_000B);
    go(); ill = 1; ebk = 1; ecl = 1; pc = 32'h5100;
    #1 check("R5 all three redirect", {31'b0, redir}, 32'h1);
    rd(1, v); check("R5 illegal wins", v, 32'h2);
    go(); ebk = 1; ecl = 1; pc = 32'h5200;
    #1;
    rd(1, v); check("R5 ebreak over ecall", v, 32'h3);

    // R5/R6/R7/R2 software traps against both enable values
    for (int e = 0; e < 2; e++) begin
      for (int t = 0; t < 3; t++) begin
        swp(0, 32'(e), v);
        go(); pc = 32'h6000 + 32'(e * 16 + t * 4);
        if (t == 0) ill = 1; else if (t == 1) ebk = 1; else ecl = 1;
        #1 check("R5 software trap taken", {31'b0, redir}, 32'h1);
        check("R8 software trap target", redir_pc, 32'h200);
        rd(0, v); check("R2 saved enable", v, 32'(e << 1));
        rd(1, v); check("R6 software cause", v, (t == 0) ? 32'h2 : (t == 1) ? 32'h3 : 32'hB);
        rd(2, v); check("R7 trapping pc", v, 32'h6000 + 32'(e * 16 + t * 4));
      end
    end

    // R12 interrupt squashes CSR write
    swp(0, 32'h1, v);
    go();
    irq = 1; acc = 1; op = 3'b001; addr = RWB + 12'd2; we = 1; wdata = 32'hCAFE_0000;
    pc = 32'h7000;
    #1 check("R12 irq taken over csr", {31'b0, redir}, 32'h1);
    rd(2, v); check("R12 csr write discarded", v, 32'h7000);

    // R8 new vector
    swp(3, 32'h400, v);
    go(); ebk = 1; pc = 32'h7100;
    #1 check("R8 new vector used", redir_pc, 32'h400);

    go();
    report();
  end
endmodule